// File: doc/BRIEF.md
# Video Channel Control and Status Register Unit

This block holds the control and status state of one channel of a frame-based video DMA engine. Software reaches it through a 32-bit register port with a write strobe, a read strobe and a word address. The control word starts and stops the channel, requests a soft reset, and selects circular operation, genlock, frame counting and the frame-sync source. It also carries three interrupt enables and two 8-bit thresholds: one for frame coalescing and one for the inter-frame delay. The effective control word is driven to the datapath on a port of its own.

The status word reports halted and idle, three interrupt flags, the latched error flags, and the live frame and delay counters. The datapath supplies frame-done pulses, a delay timer tick, per-bit error event pulses and a busy level. A single registered interrupt line is raised when any flag is set and its enable bit is on. Recoverable errors can be acknowledged by software. The remaining errors stay latched until a soft or hard reset.

Top module: `vcsr_top`

## Requirements
- R1: After reset the control word (word address 0) reads 0 and the status word (word address 1) reads 0x00010001 (halted, frame count 1). A control write without bit 2 reads back unchanged, with bit 2 reading 0.
- R2: Status bit 0 (halted) equals the inverse of control bit 0 one cycle after the control word changes. Status bit 1 (idle) is 1 when control bit 0 is set and the busy input is low.
- R3: Writing control bit 2 starts a soft reset lasting RST_CYC cycles. During the reset, control reads return exactly 0x00000004. Afterwards control bit 2 reads 0, and every control and status field, including latched non-recoverable errors, is back at its R1 value.
- R4: The frame count (status bits 23:16) decrements on each frame-done pulse. When it would reach zero, it sets the frame flag (status bit 12) and reloads from the threshold in control bits 23:16. A threshold of 0 acts as 1.
- R5: The delay count (status bits 31:24) clears on each frame-done pulse and otherwise increments on each tick, saturating at 255. It sets the delay flag (status bit 13) when it reaches a nonzero threshold in control bits 31:24. A threshold of 0 never sets the flag.
- R6: Status bits 12, 13 and 14 clear when 1 is written to them at word address 1. Writes to status bits 0, 1 and 31:16 have no effect.
- R7: An error pulse on err_evt bit k latches status bit k for k in {4..11, 15} and sets the error flag (status bit 14). Bits 4, 7, 8 and 11 clear on a write of 1. Bits 5, 6, 9, 10 and 15 ignore writes.
- R8: irq goes high one cycle after any status flag 12, 13 or 14 is set while the control bit of the same index is set. It is low whenever no enabled flag is set.
- R9: Any control write that is not a soft reset reloads the frame count from the new threshold and clears the delay count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data valid next cycle |
| bus_addr | input | ADDR_W | Word address: 0 control, 1 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| frame_done | input | 1 | One-cycle pulse per completed frame |
| dly_tick | input | 1 | Delay timer tick |
| err_evt | input | 16 | Error event pulses, one per status bit position |
| busy | input | 1 | Datapath has outstanding work |
| ctrl_word | output | 32 | Effective control word to the datapath |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong counter value becomes visible in status bits 31:16 on the very next read, and it also misplaces the cycle in which a flag and then irq rise. A wrong decision about which error bits are recoverable shows up as a bit that survives, or vanishes after, an all-ones status write. Errors in the soft reset sequencer show up in the control readback while the reset is in progress, or as a sticky error that outlives the reset. The enable gating is checked at the irq pin two cycles after a flag-setting event, both with the enable on and with it off.

// File: rtl/vcsr_pkg.sv
package vcsr_pkg;
  localparam int DW  = 32;
  localparam int CW  = 8;
  localparam int EW  = 16;
  // word addresses
  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  // control bit positions
  localparam int B_RUN  = 0;
  localparam int B_SRST = 2;
  localparam int B_IEN  = 12;
  localparam int B_FTH  = 16;
  localparam int B_DTH  = 24;
  // error bit classes in the status word
  localparam logic [EW-1:0] ERR_ALL = 16'h8FF0;
  localparam logic [EW-1:0] ERR_RCV = 16'h0990;
  // flag index inside the 3-bit flag vector
  localparam int F_FRM = 0;
  localparam int F_DLY = 1;
  localparam int F_ERR = 2;
endpackage

// File: rtl/vcsr_ctrl.sv
module vcsr_ctrl
  import vcsr_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     ctrl_q,
  output logic              soft_busy,
  output logic              thr_load
);
  localparam int RCW = $clog2(RST_CYC + 1);
  logic [RCW-1:0] rcnt;
  logic           hit;

  assign hit       = wr && (addr == ADDR_W'(A_CTRL));
  assign soft_busy = (rcnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      rcnt     <= '0;
      thr_load <= 1'b0;
    end else begin
      thr_load <= 1'b0;
      if (soft_busy) begin
        rcnt   <= rcnt - RCW'(1);
        ctrl_q <= '0;
      end else if (hit) begin
        if (wdata[B_SRST]) begin
          rcnt   <= RCW'(RST_CYC);
          ctrl_q <= '0;
        end else begin
          ctrl_q   <= wdata;
          thr_load <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vcsr_cnt.sv
module vcsr_cnt
  import vcsr_pkg::*;
(
  input  logic          clk,
  input  logic          srst,
  input  logic          load,
  input  logic [CW-1:0] fthr,
  input  logic [CW-1:0] dthr,
  input  logic          frame,
  input  logic          tick,
  output logic [CW-1:0] fcnt,
  output logic [CW-1:0] dcnt,
  output logic          frm_hit,
  output logic          dly_hit
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] DMAX = '1;
  logic [CW-1:0] feff;
  logic          live;

  assign feff    = (fthr == '0) ? ONE : fthr;
  assign live    = !srst && !load;
  assign frm_hit = live && frame && (fcnt == ONE);
  assign dly_hit = live && !frame && tick && (dcnt != DMAX) &&
                   (dthr != '0) && ((dcnt + ONE) == dthr);

  always_ff @(posedge clk) begin
    if (srst) begin
      fcnt <= ONE;
      dcnt <= '0;
    end else if (load) begin
      fcnt <= feff;
      dcnt <= '0;
    end else if (frame) begin
      fcnt <= (fcnt == ONE) ? feff : fcnt - ONE;
      dcnt <= '0;
    end else if (tick && dcnt != DMAX) begin
      dcnt <= dcnt + ONE;
    end
  end
endmodule

// File: rtl/vcsr_stat.sv
module vcsr_stat
  import vcsr_pkg::*;
(
  input  logic          clk,
  input  logic          srst,
  input  logic          run,
  input  logic          busy,
  input  logic          w1c,
  input  logic [DW-1:0] wdata,
  input  logic          frm_hit,
  input  logic          dly_hit,
  input  logic [EW-1:0] err_evt,
  input  logic [2:0]    en,
  output logic          halted,
  output logic          idle,
  output logic [2:0]    flags,
  output logic [EW-1:0] errs,
  output logic          irq
);
  logic [2:0] fset;
  logic [2:0] fclr;
  logic       err_new;

  assign err_new = |(err_evt & ERR_ALL);
  assign fset    = {err_new, dly_hit, frm_hit};
  assign fclr    = w1c ? wdata[B_IEN +: 3] : 3'b000;

  generate
    for (genvar i = 0; i < EW; i++) begin : g_err
      if (ERR_ALL[i]) begin : g_lat
        logic clr;
        assign clr = ERR_RCV[i] && w1c && wdata[i];
        always_ff @(posedge clk) begin
          if (srst)            errs[i] <= 1'b0;
          else if (err_evt[i]) errs[i] <= 1'b1;
          else if (clr)        errs[i] <= 1'b0;
        end
      end else begin : g_zero
        assign errs[i] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (srst) begin
      flags  <= '0;
      halted <= 1'b1;
      idle   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      flags  <= fset | (flags & ~fclr);
      halted <= !run;
      idle   <= run && !busy;
      irq    <= |(flags & en);
    end
  end
endmodule

// File: rtl/vcsr_top.sv
module vcsr_top
  import vcsr_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              frame_done,
  input  logic              dly_tick,
  input  logic [15:0]       err_evt,
  input  logic              busy,
  output logic [31:0]       ctrl_word,
  output logic              irq
);
  logic          soft_busy, thr_load, srst;
  logic [CW-1:0] fcnt, dcnt;
  logic          frm_hit, dly_hit, halted, idle, w1c;
  logic [2:0]    flags;
  logic [EW-1:0] errs;
  logic [DW-1:0] ctrl_rd, status_w;

  vcsr_ctrl #(.ADDR_W(ADDR_W), .RST_CYC(RST_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .ctrl_q(ctrl_word), .soft_busy(soft_busy), .thr_load(thr_load)
  );

  assign srst = rst || soft_busy;
  assign w1c  = bus_wr && (bus_addr == ADDR_W'(A_STAT));

  vcsr_cnt u_cnt (
    .clk(clk), .srst(srst), .load(thr_load),
    .fthr(ctrl_word[B_FTH +: CW]), .dthr(ctrl_word[B_DTH +: CW]),
    .frame(frame_done), .tick(dly_tick),
    .fcnt(fcnt), .dcnt(dcnt), .frm_hit(frm_hit), .dly_hit(dly_hit)
  );

  vcsr_stat u_stat (
    .clk(clk), .srst(srst), .run(ctrl_word[B_RUN]), .busy(busy),
    .w1c(w1c), .wdata(bus_wdata), .frm_hit(frm_hit), .dly_hit(dly_hit),
    .err_evt(err_evt), .en(ctrl_word[B_IEN +: 3]),
    .halted(halted), .idle(idle), .flags(flags), .errs(errs), .irq(irq)
  );

  always_comb begin
    ctrl_rd         = ctrl_word;
    ctrl_rd[B_SRST] = soft_busy;
    status_w        = {dcnt, fcnt, errs[15], flags, errs[11:2], idle, halted};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_addr == ADDR_W'(A_CTRL))      bus_rdata <= ctrl_rd;
      else if (bus_addr == ADDR_W'(A_STAT)) bus_rdata <= status_w;
      else                                  bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/vcsr_chk.sv
module vcsr_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] ctrl_word,
  input logic [31:0] status_w,
  input logic        soft_busy,
  input logic [2:0]  flags,
  input logic        irq
);
  AST_RST_CTRL_ZERO: assert property (@(posedge clk) rst |=> (ctrl_word == 32'h0)); // R1

  AST_HALT_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl_word[0]) |=> status_w[0]); // R2

  AST_SRST_CTRL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    soft_busy |-> (ctrl_word == 32'h0)); // R3

  AST_FCNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    status_w[23:16] != 8'h00); // R4

  AST_STICKY_ERR: assert property (@(posedge clk) disable iff (rst)
    status_w[9] |=> (status_w[9] || soft_busy)); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    ((flags & ctrl_word[14:12]) == 3'b000) |=> !irq); // R8
endmodule

bind vcsr_top vcsr_chk i_chk (
  .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .status_w(status_w),
  .soft_busy(soft_busy), .flags(flags), .irq(irq)
);

// File: tb/test_vcsr_top.sv
module test_vcsr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        frame_done = 1'b0, dly_tick = 1'b0, busy = 1'b0;
  logic [15:0] err_evt = '0;
  logic [31:0] ctrl_word;
  logic        irq;
  int tests = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  vcsr_top i_vcsr_top (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_done(frame_done),
    .dly_tick(dly_tick), .err_evt(err_evt), .busy(busy),
    .ctrl_word(ctrl_word), .irq(irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, act=%0d exp<%0d cycles", cyc, 50000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_FRM = 3'd2,
                         OP_TCK = 3'd3, OP_ERR = 3'd4;
  localparam int NV = 22;
  // {op, addr, data, expected}
  localparam logic [68:0] VEC [NV] = '{
    {OP_RD,  2'd0, 32'h0,        32'h0000_0000}, // R1 control default
    {OP_RD,  2'd1, 32'h0,        32'h0001_0001}, // R1 status default
    {OP_WR,  2'd0, 32'h0203_7001, 32'h0},        // R9 thresholds 3/2, run
    {OP_RD,  2'd0, 32'h0,        32'h0203_7001}, // R1 readback
    {OP_RD,  2'd1, 32'h0,        32'h0003_0002}, // R2 R9 running idle, fcnt 3
    {OP_FRM, 2'd0, 32'h0,        32'h0},
    {OP_RD,  2'd1, 32'h0,        32'h0002_0002}, // R4 decrement
    {OP_TCK, 2'd0, 32'h0,        32'h0},
    {OP_TCK, 2'd0, 32'h0,        32'h0},
    {OP_RD,  2'd1, 32'h0,        32'h0202_2002}, // R5 delay hit
    {OP_FRM, 2'd0, 32'h0,        32'h0},
    {OP_FRM, 2'd0, 32'h0,        32'h0},
    {OP_RD,  2'd1, 32'h0,        32'h0003_3002}, // R4 reload + flag
    {OP_WR,  2'd1, 32'h0000_3000, 32'h0},
    {OP_RD,  2'd1, 32'h0,        32'h0003_0002}, // R6 write-one-clear
    {OP_ERR, 2'd0, 32'h0000_0210, 32'h0},
    {OP_RD,  2'd1, 32'h0,        32'h0003_4212}, // R7 latch
    {OP_WR,  2'd1, 32'hFFFF_FFFF, 32'h0},
    {OP_RD,  2'd1, 32'h0,        32'h0003_0202}, // R7 R6 sticky bit 9
    {OP_WR,  2'd0, 32'h0000_0000, 32'h0},
    {OP_RD,  2'd0, 32'h0,        32'h0000_0000}, // R1 stop
    {OP_RD,  2'd1, 32'h0,        32'h0001_0201}  // R2 R9 halted, fcnt 1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse(input logic [2:0] op, input logic [15:0] e);
    @(negedge clk);
    if (op == OP_FRM) frame_done = 1'b1;
    if (op == OP_TCK) dly_tick = 1'b1;
    if (op == OP_ERR) err_evt = e;
    @(negedge clk); frame_done = 1'b0; dly_tick = 1'b0; err_evt = '0;
  endtask

  task automatic idle_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1'b1;
    idle_cyc(2); rst = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    idle_cyc(3); rst = 1'b0;
    check("R8 irq after reset", {31'b0, irq}, 32'h0);
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][68:66])
        OP_WR: wr(VEC[i][65:64], VEC[i][63:32]);
        OP_RD: begin
          rd(VEC[i][65:64], v);
          check($sformatf("R-vec%0d", i), v, VEC[i][31:0]);
        end
        default: pulse(VEC[i][68:66], VEC[i][47:32]);
      endcase
    end

    // R8: enabled frame flag raises irq; disabling the enable drops it
    do_reset();
    wr(2'd0, 32'h0000_1000);
    pulse(OP_FRM, '0);
    idle_cyc(1);
    check("R8 irq enabled", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h0000_0000);
    idle_cyc(1);
    check("R8 irq masked", {31'b0, irq}, 32'h0);
    rd(2'd1, v);
    check("R6 flag held until cleared", v, 32'h0001_1001);

    // R2: idle follows busy while running
    do_reset();
    wr(2'd0, 32'h0000_0001);
    busy = 1'b1; idle_cyc(3);
    rd(2'd1, v);
    check("R2 busy not idle", v, 32'h0001_0000);
    busy = 1'b0; idle_cyc(2);
    rd(2'd1, v);
    check("R2 idle", v, 32'h0001_0002);

    // R3: soft reset readback, self-clear, sticky error wiped
    pulse(OP_ERR, 16'h0200);
    rd(2'd1, v);
    check("R7 nonrecoverable latched", v, 32'h0001_4202);
    wr(2'd0, 32'h0000_0004);
    rd(2'd0, v);
    check("R3 reset in progress", v, 32'h0000_0004);
    idle_cyc(8);
    rd(2'd0, v);
    check("R3 self-clear", v, 32'h0000_0000);
    rd(2'd1, v);
    check("R3 status default", v, 32'h0001_0001);

    // R5: zero delay threshold counts but never flags
    wr(2'd0, 32'h0000_2000);
    pulse(OP_TCK, '0); pulse(OP_TCK, '0); pulse(OP_TCK, '0);
    rd(2'd1, v);
    check("R5 zero threshold", v, 32'h0301_0001);
    check("R5 R8 no irq", {31'b0, irq}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule